// File: doc/BRIEF.md
# SPI Master Controller with Status Flags

This block is a byte-wide SPI master that sits on a small register bus. Software sets the mode, clock rate and interrupt enable through a control register. It writes a byte to the data register, and that write starts a full-duplex exchange on SCK, MOSI and MISO. When the exchange ends, the received byte waits in a receive buffer and a completion flag rises. That flag can raise an interrupt request.

Two error conditions are tracked. A write collision happens when the data register is written during an exchange. A mode fault happens when the slave-select pin is used as an input and is pulled low while the block is master. Flags are cleared either by an interrupt acknowledge or by a two-step sequence: a status read that sees a flag set, followed by any data register access.

Top module: `spi_status_ctrl`

## Requirements
- R1: After reset the control register, status register and `irq` read 0, and `sck` is low.
- R2: Address 0 is control, with these bits: 7 interrupt enable, 6 enable, 4 master, 3 CPOL, 2 CPHA, 1:0 rate; bit 5 reads 0. Address 1 is status, with these bits: 7 completion flag, 6 collision flag, 0 writable double-speed bit; bits 5:1 read 0. Address 2 is data.
- R3: A data write while enabled, master and idle starts an 8-bit MSB-first exchange, and `mosi` shows bit 7 right after the write.
- R4: A data read returns the last fully received byte. The receive buffer changes only when an exchange completes.
- R5: The completion flag rises exactly 8*D clock cycles after the write edge. D is 4, 16, 64 or 128 for rate 0..3, and is halved when the double-speed bit is 1.
- R6: `sck` idles at CPOL and toggles 16 times per exchange. In all four CPOL/CPHA modes, data is shifted out on one edge and sampled on the other, so looped-back data is received intact.
- R7: `irq` equals the completion flag ANDed with interrupt enable, and `irq_ack` clears the completion flag.
- R8: A data write during an exchange sets the collision flag. The written byte is discarded and the running exchange is unaffected.
- R9: A status read that sees a flag set, followed by a data access, clears both flags. A data access without that prior read leaves the flags unchanged.
- R10: With `ss_is_input` high, `ss_n` low while enabled as master sets the completion flag, clears the master bit and aborts any exchange without updating the receive buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request |
| ss_is_input | input | 1 | Slave-select pin is configured as input |
| ss_n | input | 1 | Slave-select pin level |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench uses the default parameters: an 8-bit data width and a 7-bit divider counter. With these values every rate setting is reachable, from the 2-cycle SCK period up to the 128-cycle one, and even the slowest exchange stays at about a thousand cycles. This lets the bench time each rate and double-speed combination exactly. It also runs all four CPOL/CPHA modes through a loopback with and without inversion, and it can stop a slow exchange in the middle to inject a mode fault.

// File: rtl/spi_pkg.sv
package spi_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic       ie;
        logic       en;
        logic       mst;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } spi_ctrl_t;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    input  logic       dbl,
    output logic       tick
);
    logic [7:0]       base_div;
    logic [7:0]       half_div;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        case (rate)
            2'd0:    base_div = 8'd4;
            2'd1:    base_div = 8'd16;
            2'd2:    base_div = 8'd64;
            default: base_div = 8'd128;
        endcase
        half_div = dbl ? (base_div >> 2) : (base_div >> 1);
        lim      = CNT_W'(half_div - 8'd1);
        tick     = run && (cnt_q == lim);
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> cnt_q == '0);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int DW = spi_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [DW-1:0] din,
    input  logic          tick,
    input  logic          cpha,
    input  logic          miso,
    output logic          busy,
    output logic          phase,
    output logic          mosi,
    output logic          done,
    output logic [DW-1:0] rx_byte
);
    localparam int NEDGE = 2 * DW;
    localparam int EW    = $clog2(NEDGE);

    typedef struct packed {
        logic          busy;
        logic          ph;
        logic [EW-1:0] edge_n;
        logic [DW-1:0] sr;
        logic          samp;
    } sh_t;

    sh_t s_d, s_q;
    logic lead, sample_now;

    always_comb begin
        s_d        = s_q;
        done       = 1'b0;
        lead       = ~s_q.edge_n[0];
        sample_now = cpha ? !lead : lead;
        if (abort) begin
            s_d.busy = 1'b0;
            s_d.ph   = 1'b0;
        end else if (start) begin
            s_d.busy   = 1'b1;
            s_d.ph     = 1'b0;
            s_d.edge_n = '0;
            s_d.sr     = din;
            s_d.samp   = 1'b0;
        end else if (s_q.busy && tick) begin
            s_d.ph     = ~s_q.ph;
            s_d.edge_n = s_q.edge_n + 1'b1;
            if (sample_now)
                s_d.samp = miso;
            else if (!(cpha && s_q.edge_n == '0))
                s_d.sr = {s_q.sr[DW-2:0], s_q.samp};
            if (s_q.edge_n == EW'(NEDGE - 1)) begin
                s_d.busy = 1'b0;
                done     = 1'b1;
            end
        end
        rx_byte = cpha ? {s_q.sr[DW-2:0], miso} : {s_q.sr[DW-2:0], s_q.samp};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy  = s_q.busy;
    assign phase = s_q.ph;
    assign mosi  = s_q.sr[DW-1];

    // R6
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy |-> !s_q.ph);
    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic data_acc,
    input  logic coll,
    input  logic done,
    input  logic fault,
    input  logic ack,
    output logic cmpl_flag,
    output logic coll_flag
);
    typedef struct packed {
        logic cmpl;
        logic coll;
        logic arm;
    } fl_t;

    fl_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (stat_rd && (f_q.cmpl || f_q.coll)) f_d.arm = 1'b1;
        else if (data_acc)                     f_d.arm = 1'b0;
        if (data_acc && f_q.arm) begin
            f_d.cmpl = 1'b0;
            f_d.coll = 1'b0;
        end
        if (ack)          f_d.cmpl = 1'b0;
        if (coll)         f_d.coll = 1'b1;
        if (done || fault) f_d.cmpl = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign cmpl_flag = f_q.cmpl;
    assign coll_flag = f_q.coll;

    // R9
    cmpl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(f_q.cmpl) |-> $past(ack || (data_acc && f_q.arm)));
    // R8
    coll_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.coll) |-> $past(coll));
endmodule

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl #(
    parameter int DW    = spi_pkg::DATA_W,
    parameter int CNT_W = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          irq_ack,
    output logic          irq,
    input  logic          ss_is_input,
    input  logic          ss_n,
    output logic          sck,
    output logic          mosi,
    input  logic          miso
);
    import spi_pkg::*;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    typedef struct packed {
        spi_ctrl_t     ctrl;
        logic          dbl;
        logic [DW-1:0] rxbuf;
    } top_t;

    top_t r_d, r_q;
    logic busy, phase, done, tick, cmpl_flag, coll_flag;
    logic data_wr, data_acc, stat_rd, fault, start, coll;
    logic [DW-1:0] rx_byte;

    always_comb begin
        data_wr  = bus_wr && bus_addr == A_DATA;
        data_acc = (bus_wr || bus_rd) && bus_addr == A_DATA;
        stat_rd  = bus_rd && bus_addr == A_STAT;
        fault    = r_q.ctrl.en && r_q.ctrl.mst && ss_is_input && !ss_n;
        start    = data_wr && r_q.ctrl.en && r_q.ctrl.mst && !busy && !fault;
        coll     = data_wr && busy;

        r_d = r_q;
        if (bus_wr && bus_addr == A_CTRL)
            r_d.ctrl = '{ie: bus_wdata[7], en: bus_wdata[6], mst: bus_wdata[4],
                         cpol: bus_wdata[3], cpha: bus_wdata[2], rate: bus_wdata[1:0]};
        if (bus_wr && bus_addr == A_STAT) r_d.dbl = bus_wdata[0];
        if (fault) r_d.ctrl.mst = 1'b0;
        if (done)  r_d.rxbuf = rx_byte;

        case (bus_addr)
            A_CTRL:  bus_rdata = {r_q.ctrl.ie, r_q.ctrl.en, 1'b0, r_q.ctrl.mst,
                                  r_q.ctrl.cpol, r_q.ctrl.cpha, r_q.ctrl.rate};
            A_STAT:  bus_rdata = {cmpl_flag, coll_flag, {(DW-3){1'b0}}, r_q.dbl};
            A_DATA:  bus_rdata = r_q.rxbuf;
            default: bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    spi_clk_div #(.CNT_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .rate(r_q.ctrl.rate),
        .dbl(r_q.dbl), .tick(tick));

    spi_shifter #(.DW(DW)) u_sh (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(fault), .din(bus_wdata),
        .tick(tick), .cpha(r_q.ctrl.cpha), .miso(miso), .busy(busy),
        .phase(phase), .mosi(mosi), .done(done), .rx_byte(rx_byte));

    spi_flag_unit u_fl (
        .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_acc(data_acc),
        .coll(coll), .done(done), .fault(fault), .ack(irq_ack),
        .cmpl_flag(cmpl_flag), .coll_flag(coll_flag));

    assign sck = r_q.ctrl.cpol ^ phase;
    assign irq = cmpl_flag && r_q.ctrl.ie;

    // R4
    rxbuf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(done) |-> $stable(r_q.rxbuf));
    // R10
    fault_demote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !r_q.ctrl.mst && !busy && cmpl_flag);
endmodule

// File: tb/tb_spi_status_ctrl.sv
module tb_spi_status_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, irq_ack = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic irq, sck, mosi, miso;
    logic ss_is_input = 1'b0, ss_n = 1'b1, inv = 1'b0;
    int total = 0, bad = 0;
    logic [7:0] last_rx = 8'h00;

    always #4 clk = ~clk;
    assign miso = inv ? ~mosi : mosi;

    spi_status_ctrl dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 0);
        rd(2'd1, v); chk(v == 8'h00, "R1 status", v, 0);
        chk(irq == 1'b0 && sck == 1'b0, "R1 irq/sck", {irq, sck}, 0);
    endtask

    task automatic t_layout();
        logic [7:0] v;
        wr(2'd0, 8'hFF); rd(2'd0, v); chk(v == 8'hDF, "R2 ctrl bit5", v, 8'hDF);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hFF); rd(2'd1, v); chk(v == 8'h01, "R2 status bits", v, 8'h01);
        wr(2'd1, 8'h00);
    endtask

    task automatic xfer(input bit cpol, input bit cpha, input logic [1:0] rate,
                        input bit dbl, input logic [7:0] d, input bit inv_in);
        int n, tog, div;
        logic prev;
        logic [7:0] v, exp;
        inv = inv_in;
        wr(2'd1, {7'd0, dbl});
        wr(2'd0, {2'b11, 1'b0, 1'b1, cpol, cpha, rate});
        ack();
        wr(2'd2, d);
        chk(mosi == d[7], "R3 msb first", mosi, d[7]);
        div = (rate == 2'd3) ? 128 : (4 << (2 * rate));
        if (dbl) div = div / 2;
        n = 1; tog = 0; prev = sck;
        while (!irq && n < 5000) begin
            @(posedge clk); #1;
            if (sck != prev) tog++;
            prev = sck;
            if (!irq) n++;
        end
        chk(n == 8 * div, "R5 duration", n, 8 * div);
        chk(tog == 16 && sck == cpol, "R6 sck edges/idle", tog, 16);
        exp = inv_in ? ~d : d;
        rd(2'd2, v);
        chk(v == exp, "R6 R4 received byte", v, exp);
        last_rx = exp;
    endtask

    task automatic t_modes();
        xfer(0, 0, 2'd0, 0, 8'hA5, 0);
        xfer(0, 1, 2'd0, 0, 8'h3C, 1);
        xfer(1, 0, 2'd0, 0, 8'h81, 1);
        xfer(1, 1, 2'd0, 0, 8'h5E, 0);
        xfer(0, 0, 2'd1, 0, 8'h12, 1);
        xfer(1, 0, 2'd2, 0, 8'hC7, 0);
        xfer(0, 1, 2'd3, 0, 8'h69, 1);
        xfer(0, 0, 2'd0, 1, 8'hF0, 0);
        xfer(1, 1, 2'd3, 1, 8'h0F, 1);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        inv = 1'b0;
        wr(2'd1, 8'h00); wr(2'd0, 8'hD0); ack();
        wr(2'd2, 8'hA5);
        repeat (5) @(negedge clk);
        wr(2'd2, 8'h3C);
        rd(2'd2, v); chk(v == last_rx, "R4 buffer holds during transfer", v, last_rx);
        wait (irq == 1'b1); #1;
        rd(2'd1, v); chk(v == 8'hC0, "R8 both flags", v, 8'hC0);
        rd(2'd2, v); chk(v == 8'hA5, "R8 transfer undisturbed", v, 8'hA5);
        last_rx = v;
        rd(2'd1, v); chk(v == 8'h00, "R9 clear after sequence", v, 0);
    endtask

    task automatic t_clear();
        logic [7:0] v;
        wr(2'd0, 8'hD0); wr(2'd2, 8'h77);
        wait (irq == 1'b1); #1;
        rd(2'd2, v); last_rx = v;
        rd(2'd1, v); chk(v == 8'h80, "R9 no prior read keeps flag", v, 8'h80);
        ack(); #1 chk(irq == 1'b0, "R7 ack clears", irq, 0);
        rd(2'd1, v); chk(v == 8'h00, "R7 flag after ack", v, 0);
        wr(2'd0, 8'h50); wr(2'd2, 8'h99);
        repeat (60) @(negedge clk);
        chk(irq == 1'b0, "R7 masked irq", irq, 0);
        rd(2'd1, v); chk(v == 8'h80, "R7 flag set while masked", v, 8'h80);
        rd(2'd2, v); last_rx = v;
        rd(2'd1, v); chk(v == 8'h00, "R9 read then data read", v, 0);
    endtask

    task automatic t_fault();
        logic [7:0] v;
        ss_is_input = 1'b1;
        wr(2'd0, 8'h53); wr(2'd2, 8'hEE);
        repeat (40) @(negedge clk);
        ss_n = 1'b0;
        @(negedge clk); ss_n = 1'b1;
        #1 chk(sck == 1'b0, "R10 sck idle after abort", sck, 0);
        rd(2'd0, v); chk(v == 8'h43, "R10 master cleared", v, 8'h43);
        rd(2'd1, v); chk(v == 8'h80, "R10 flag set", v, 8'h80);
        repeat (1200) @(negedge clk);
        rd(2'd2, v); chk(v == last_rx, "R10 buffer untouched", v, last_rx);
        ss_is_input = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_layout();
                t_modes();
                t_collision();
                t_clear();
                t_fault();
            end
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule